// File: doc/BRIEF.md
# Two-Wire Serial Programming Target

This block is the device-side half of a two-wire programming port for a small one-time-programmable microcontroller. An external programmer toggles a slow clock pin and drives a data pin. The block samples both pins in the system clock domain through synchronizers and decodes 6-bit commands. For load and read commands it then moves a 14-bit word inside a 16-clock frame. The data pin is shared by the programmer and the target: it is split into an input, an output and an output enable, and the target takes the pin only for the data slots of a read frame.

An internal address counter selects the memory word. It starts in user space, steps on an increment command, and jumps to a fixed configuration region on a load-configuration command. Reads go to a synchronous memory port. The last loaded word is presented as write data, and a programming-active output is held from a begin command to an end command. A single mode-enable input stands in for high-voltage entry to the mode. Dropping it returns every piece of state to its entry condition.

Top module: `serprog_target`

## Requirements
- R1: A command is 6 bits on `pdat_i`, least significant bit first, each bit taken at a falling edge of `pclk_i`. As 6-bit values the codes are: 0x00 load configuration, 0x02 load data, 0x04 read, 0x06 increment address, 0x08 begin programming, 0x0E end programming.
- R2: A load-data command is followed by a 16-clock frame. The bits taken at falling edges 2 through 15 form the word, least significant bit first. At the end of the frame the word appears on `mem_wdata_o`.
- R3: A read command pulses `mem_rd_o` for one cycle with the current address on `mem_addr_o`. `mem_rdata_i` is taken one cycle later. In the 16-clock frame that follows, `pdat_oe_o` rises on the 2nd rising edge of `pclk_i`. Bit k of the word is driven on rising edge k+2. The pin is released on the 16th rising edge.
- R4: Load configuration sets the address to 0x2000 and takes a data frame like R2. After that, increments keep the address at or above 0x2000 until the mode is left.
- R5: Increment address adds one to `mem_addr_o`.
- R6: A begin command received after a completed load frame asserts `prog_o`. `prog_o` stays high until an end command. Each load allows one begin.
- R7: A begin command with no load since the previous begin leaves `prog_o` low and sets `seq_err_o`. `seq_err_o` stays set while the mode stays enabled.
- R8: While `mode_en_i` is low, the command shifter, frame state, address, `pdat_oe_o`, `prog_o`, `seq_err_o` and the load flag are cleared within one system clock. Pin activity is ignored. After the mode is re-entered, addressing is in user space at 0.
- R9: A 6-bit code not listed in R1 changes no output and starts no frame.
- R10: After `rst_ni` is released, `mem_addr_o` is 0 and `pdat_oe_o`, `prog_o`, `mem_rd_o` and `seq_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the programming clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_en_i | input | 1 | Programming mode enable; low clears all state |
| pclk_i | input | 1 | Programming clock pin |
| pdat_i | input | 1 | Data pin, input side |
| pdat_o | output | 1 | Data pin, output side |
| pdat_oe_o | output | 1 | Data pin output enable |
| mem_addr_o | output | ADDR_W | Current word address |
| mem_rd_o | output | 1 | One-cycle memory read strobe |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after the strobe |
| mem_wdata_o | output | DATA_W | Last loaded word |
| prog_o | output | 1 | Programming pulse active |
| seq_err_o | output | 1 | Sticky flag for a begin without a preceding load |

## Verification
The collision that matters is a mode exit that lands in the same system cycle as the final falling edge of a load frame. The bench drops `mode_en_i` in the same cycle that it drives the 16th falling edge. The load-completion pulse therefore meets the clear. The bench then re-enters the mode and issues a begin. The outcome is correct only if `prog_o` stays low and `seq_err_o` rises, which shows that the half-finished load did not survive the exit, and the address reads back as 0. A second exit made while a read frame is driving the pin must release `pdat_oe_o` at once.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  localparam int CMD_W = 6;

  localparam logic [CMD_W-1:0] CMD_LD_CFG  = 6'h00;
  localparam logic [CMD_W-1:0] CMD_LD_DATA = 6'h02;
  localparam logic [CMD_W-1:0] CMD_READ    = 6'h04;
  localparam logic [CMD_W-1:0] CMD_INC     = 6'h06;
  localparam logic [CMD_W-1:0] CMD_BEGIN   = 6'h08;
  localparam logic [CMD_W-1:0] CMD_END     = 6'h0E;

  typedef enum logic [1:0] {
    FS_CMD  = 2'd0,
    FS_LOAD = 2'd1,
    FS_READ = 2'd2
  } fstate_e;
endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st_q[s] <= '0;
      else if (clr_i) st_q[s] <= '0;
      else if (s == 0) st_q[s] <= d_i;
      else            st_q[s] <= st_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/serprog_frame.sv
module serprog_frame
  import serprog_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              rdata_vld_i,
  output logic              cmd_vld_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              ld_done_o,
  output logic [DATA_W-1:0] word_o,
  output logic              dout_o,
  output logic              oe_o
);
  localparam int FRAME_LEN = DATA_W + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_FRM = CNT_W'(FRAME_LEN - 1);

  fstate_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CMD_W-1:0]  cmd_sh_q;
  logic [CMD_W-1:0]  cmd_next;
  logic [DATA_W-1:0] word_q;
  logic              in_data;

  assign cmd_next = {din_i, cmd_sh_q[CMD_W-1:1]};
  assign in_data  = (cnt_q != '0) && (cnt_q <= LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= FS_CMD; cnt_q <= '0; cmd_sh_q <= '0; word_q <= '0;
      cmd_vld_o <= 1'b0; cmd_o <= '0; ld_done_o <= 1'b0;
      dout_o <= 1'b0; oe_o <= 1'b0;
    end else if (clr_i) begin
      st_q <= FS_CMD; cnt_q <= '0; cmd_sh_q <= '0; word_q <= '0;
      cmd_vld_o <= 1'b0; cmd_o <= '0; ld_done_o <= 1'b0;
      dout_o <= 1'b0; oe_o <= 1'b0;
    end else begin
      cmd_vld_o <= 1'b0;
      ld_done_o <= 1'b0;
      unique case (st_q)
        FS_CMD: if (fall_i) begin
          cmd_sh_q <= cmd_next;
          if (cnt_q == LAST_CMD) begin
            cnt_q     <= '0;
            cmd_vld_o <= 1'b1;
            cmd_o     <= cmd_next;
            if (cmd_next == CMD_LD_CFG || cmd_next == CMD_LD_DATA) st_q <= FS_LOAD;
            else if (cmd_next == CMD_READ)                         st_q <= FS_READ;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        FS_LOAD: if (fall_i) begin
          if (in_data) word_q <= {din_i, word_q[DATA_W-1:1]};
          if (cnt_q == LAST_FRM) begin
            cnt_q <= '0; st_q <= FS_CMD; ld_done_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        FS_READ: begin
          if (rdata_vld_i) word_q <= rdata_i;
          if (rise_i) begin
            if (in_data) begin
              oe_o   <= 1'b1;
              dout_o <= word_q[0];
              word_q <= word_q >> 1;
            end else if (cnt_q == LAST_FRM) begin
              oe_o <= 1'b0;
            end
          end
          if (fall_i) begin
            if (cnt_q == LAST_FRM) begin
              cnt_q <= '0; st_q <= FS_CMD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: st_q <= FS_CMD;
      endcase
    end
  end

  assign word_o = word_q;

  // R3
  oe_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> st_q == FS_READ);

  // R2
  load_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_done_o |-> (st_q == FS_CMD && $past(st_q) == FS_LOAD));
endmodule

// File: rtl/serprog_pc.sv
module serprog_pc #(
  parameter int ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic              cfg_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(1) << (ADDR_W - 1);

  logic [ADDR_W-1:0] pc_q;
  logic              cfg_q;
  logic [ADDR_W-1:0] pc_inc;

  assign pc_inc = cfg_q ? ((pc_q + 1'b1) | CFG_BASE) : (pc_q + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0; cfg_q <= 1'b0;
    end else if (clr_i) begin
      pc_q <= '0; cfg_q <= 1'b0;
    end else if (cfg_i) begin
      pc_q <= CFG_BASE; cfg_q <= 1'b1;
    end else if (inc_i) begin
      pc_q <= pc_inc;
    end
  end

  assign pc_o = pc_q;

  // R4
  cfg_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q |-> (pc_q & CFG_BASE) == CFG_BASE);

  // R5
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !cfg_i && !clr_i && !cfg_q) |=> pc_q == $past(pc_q) + 1'b1);
endmodule

// File: rtl/serprog_target.sv
module serprog_target
  import serprog_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_en_i,
  input  logic              pclk_i,
  input  logic              pdat_i,
  output logic              pdat_o,
  output logic              pdat_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              prog_o,
  output logic              seq_err_o
);
  logic              clr;
  logic [1:0]        pin_s;
  logic              pclk_d_q;
  logic              rise, fall;
  logic              cmd_vld, ld_done;
  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] word;
  logic              rd_vld_q;
  logic              loaded_q, prog_q, err_q;
  logic [DATA_W-1:0] wdata_q;

  assign clr = !mode_en_i;

  serprog_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .clr_i(clr), .d_i({pdat_i, pclk_i}), .q_o(pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pclk_d_q <= 1'b0;
    else if (clr)   pclk_d_q <= 1'b0;
    else            pclk_d_q <= pin_s[0];
  end

  assign rise = pin_s[0] & ~pclk_d_q;
  assign fall = ~pin_s[0] & pclk_d_q;

  serprog_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i, .rst_ni, .clr_i(clr), .rise_i(rise), .fall_i(fall), .din_i(pin_s[1]),
    .rdata_i(mem_rdata_i), .rdata_vld_i(rd_vld_q),
    .cmd_vld_o(cmd_vld), .cmd_o(cmd), .ld_done_o(ld_done), .word_o(word),
    .dout_o(pdat_o), .oe_o(pdat_oe_o)
  );

  serprog_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk_i, .rst_ni, .clr_i(clr),
    .inc_i(cmd_vld && cmd == CMD_INC),
    .cfg_i(cmd_vld && cmd == CMD_LD_CFG),
    .pc_o(mem_addr_o)
  );

  assign mem_rd_o = cmd_vld && cmd == CMD_READ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q <= 1'b0; loaded_q <= 1'b0; prog_q <= 1'b0; err_q <= 1'b0; wdata_q <= '0;
    end else if (clr) begin
      rd_vld_q <= 1'b0; loaded_q <= 1'b0; prog_q <= 1'b0; err_q <= 1'b0;
    end else begin
      rd_vld_q <= mem_rd_o;
      if (ld_done) begin
        loaded_q <= 1'b1;
        wdata_q  <= word;
      end
      if (cmd_vld && cmd == CMD_BEGIN) begin
        if (loaded_q) begin
          prog_q   <= 1'b1;
          loaded_q <= 1'b0;
        end else begin
          err_q <= 1'b1;
        end
      end
      if (cmd_vld && cmd == CMD_END) prog_q <= 1'b0;
    end
  end

  assign mem_wdata_o = wdata_q;
  assign prog_o      = prog_q;
  assign seq_err_o   = err_q;

  // R6
  prog_needs_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_o) |-> $past(loaded_q));

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_err_o && mode_en_i) |=> seq_err_o);

  // R8
  mode_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> (mem_addr_o == '0 && !pdat_oe_o && !prog_o && !seq_err_o));
endmodule

// File: tb/serprog_target_tb_top.sv
`timescale 1ns/1ps
module serprog_target_tb_top;
  localparam int AW = 14;
  localparam int DW = 14;

  typedef struct packed {
    logic [5:0]    cmd;
    logic [DW-1:0] data;
    logic [AW-1:0] pc;
    logic          prog;
    logic          err;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{6'h02, 14'h1234, 14'h0000, 1'b0, 1'b0},
    '{6'h08, 14'h0000, 14'h0000, 1'b1, 1'b0},
    '{6'h0E, 14'h0000, 14'h0000, 1'b0, 1'b0},
    '{6'h08, 14'h0000, 14'h0000, 1'b0, 1'b1},
    '{6'h06, 14'h0000, 14'h0001, 1'b0, 1'b1},
    '{6'h06, 14'h0000, 14'h0002, 1'b0, 1'b1},
    '{6'h04, 14'h0000, 14'h0002, 1'b0, 1'b1},
    '{6'h02, 14'h3ABC, 14'h0002, 1'b0, 1'b1},
    '{6'h08, 14'h0000, 14'h0002, 1'b1, 1'b1},
    '{6'h0E, 14'h0000, 14'h0002, 1'b0, 1'b1},
    '{6'h00, 14'h2AAA, 14'h2000, 1'b0, 1'b1},
    '{6'h04, 14'h0000, 14'h2000, 1'b0, 1'b1},
    '{6'h06, 14'h0000, 14'h2001, 1'b0, 1'b1},
    '{6'h04, 14'h0000, 14'h2001, 1'b0, 1'b1},
    '{6'h3F, 14'h0000, 14'h2001, 1'b0, 1'b1},
    '{6'h02, 14'h0001, 14'h2001, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_en = 1'b0;
  logic pclk = 1'b0;
  logic pdat = 1'b0;
  logic pdat_o, pdat_oe, mem_rd, prog, seq_err;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] mem_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serprog_target #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_en_i(mode_en),
    .pclk_i(pclk), .pdat_i(pdat), .pdat_o(pdat_o), .pdat_oe_o(pdat_oe),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata),
    .mem_wdata_o(mem_wdata), .prog_o(prog), .seq_err_o(seq_err)
  );

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return DW'(a) ^ 14'h2A5A;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_f(mem_addr);

  function automatic string tag_of(input logic [5:0] c);
    case (c)
      6'h00: return "R4";
      6'h02: return "R2";
      6'h04: return "R3";
      6'h06: return "R5";
      6'h08: return "R6 R7";
      6'h0E: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pbit(input logic b);
    pdat = b; pclk = 1'b1;
    repeat (8) @(negedge clk);
    pclk = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // R1: six bits, LSB first
  task automatic send_cmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) pbit(c[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic load_frame(input logic [DW-1:0] d);
    pbit(1'b0);
    for (int i = 0; i < DW; i++) pbit(d[i]);
    pbit(1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic read_frame(output logic [DW-1:0] w, output bit oe_ok);
    w = '0; oe_ok = 1;
    for (int r = 1; r <= 16; r++) begin
      pclk = 1'b1;
      repeat (6) @(negedge clk);
      if (pdat_oe !== ((r >= 2) && (r <= 15))) oe_ok = 0;
      if (r >= 2 && r <= 15) w[r-2] = pdat_o;
      repeat (2) @(negedge clk);
      pclk = 1'b0;
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    finish_run();
  end

  initial begin
    logic [DW-1:0] w;
    bit oe_ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10
    chk(mem_addr == '0 && !pdat_oe && !prog && !seq_err && !mem_rd, "R10",
        {mem_addr, pdat_oe, prog, seq_err, mem_rd}, 32'h0);
    mode_en = 1'b1;
    repeat (4) @(negedge clk);

    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      send_cmd(v.cmd);
      if (v.cmd == 6'h00 || v.cmd == 6'h02) begin
        load_frame(v.data);
        chk(mem_wdata == v.data, {tag_of(v.cmd), " R2 wdata"}, 32'(mem_wdata), 32'(v.data));
      end else if (v.cmd == 6'h04) begin
        read_frame(w, oe_ok);
        chk(w == mem_f(v.pc), "R3 word", 32'(w), 32'(mem_f(v.pc)));
        chk(oe_ok, "R3 oe window", 32'(oe_ok), 32'd1);
      end
      chk(mem_addr == v.pc, {tag_of(v.cmd), " R1 addr"}, 32'(mem_addr), 32'(v.pc));
      chk(prog == v.prog, {tag_of(v.cmd), " prog"}, 32'(prog), 32'(v.prog));
      chk(seq_err == v.err, {tag_of(v.cmd), " err"}, 32'(seq_err), 32'(v.err));
    end

    // R8: mode exit lands with final falling edge of a load frame
    send_cmd(6'h02);
    pbit(1'b0);
    for (int i = 0; i < DW; i++) pbit(1'b1);
    pdat = 1'b0; pclk = 1'b1;
    repeat (8) @(negedge clk);
    pclk = 1'b0; mode_en = 1'b0;
    repeat (4) @(negedge clk);
    chk(mem_addr == '0 && !prog && !seq_err && !pdat_oe, "R8 exit clear",
        {mem_addr, prog, seq_err, pdat_oe}, 32'h0);
    mode_en = 1'b1;
    repeat (4) @(negedge clk);
    send_cmd(6'h08);
    chk(!prog, "R8 R6 no stale load", 32'(prog), 32'd0);
    chk(seq_err, "R7 begin w/o load", 32'(seq_err), 32'd1);
    send_cmd(6'h04);
    read_frame(w, oe_ok);
    chk(w == mem_f('0), "R8 user space read", 32'(w), 32'(mem_f('0)));

    // R8: exit while the pin is driven
    send_cmd(6'h06);
    send_cmd(6'h04);
    for (int r = 1; r <= 5; r++) begin
      pclk = 1'b1; repeat (8) @(negedge clk);
      pclk = 1'b0; repeat (8) @(negedge clk);
    end
    pclk = 1'b1; repeat (6) @(negedge clk);
    chk(pdat_oe, "R3 oe mid frame", 32'(pdat_oe), 32'd1);
    mode_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!pdat_oe && mem_addr == '0, "R8 oe release", {pdat_oe, mem_addr}, 32'h0);
    pclk = 1'b0;
    repeat (4) @(negedge clk);
    // R8: pin toggles ignored while disabled
    for (int i = 0; i < 6; i++) pbit(1'b0);
    chk(mem_addr == '0 && !mem_rd && !prog, "R8 ignore pins", {mem_addr, prog}, 32'h0);

    finish_run();
  end
endmodule